// File: doc/BRIEF.md
# Command Queue Consumer Engine

This block runs a small circular command queue on behalf of a host. The host fills slots of a local command RAM through a dedicated write port. Each slot holds a 128-bit command made of two 64-bit words. The host then publishes a new producer index through a small register interface. While the queue is enabled, the engine reads commands one at a time in slot order and decodes their opcodes. It advances the consumer index, which the host polls to learn when its work has drained.

Recognised invalidation and prefetch commands raise one strobe bit per opcode for exactly one cycle. The parameters decoded from the command are presented alongside the strobe. A sync command is a barrier. Its completion strobe fires only after every command written ahead of it has been consumed, and it carries the sync payload. An opcode outside the supported set halts consumption and raises a sticky error flag meant for the global error logic. The index registers are five bits wide: a four-bit slot number plus a wrap bit. This lets the engine tell a full queue from an empty one without an extra counter.

Top module: `cmdq_engine`

## Requirements
- R1: After reset, all four host registers read zero: control, producer, consumer and error. No strobe is active, and `cmd_err` and `q_full` are low.
- R2: While the enable bit (bit 0 of register select 0) is clear, no command is consumed, even if the producer index (select 1) is ahead of the consumer index (select 2). No strobe fires during this time.
- R3: Each command is handled in exactly two clock edges. The first edge reads the RAM and the second decodes it. On the second edge the consumer index increments by one, and its bit 4 toggles each time the slot number passes 15. Strobes last exactly one cycle.
- R4: A consumed command raises exactly one bit of `op_stb`, chosen by opcode (bits 7:0 of word 0): 0x01→bit0, 0x03→bit1, 0x04→bit2, 0x05→bit3, 0x06→bit4, 0x11→bit5, 0x20→bit6, 0x30→bit7.
- R5: Opcode 0x11 presents word-0 bits 63:48 on `cmd_asid` and bits 47:32 on `cmd_vmid`, both in the strobe cycle.
- R6: Opcode 0x04 presents word-1 bits 4:0 on `cmd_range` in the strobe cycle. The value 0x1f means everything.
- R7: Opcode 0x46 pulses `sync_stb`, never together with `op_stb`. At that point the consumer index already covers every earlier command. `sync_cs` is word-0 bits 13:12 and `sync_data` is word-0 bits 63:32.
- R8: Any other opcode sets `cmd_err`, which also reads as bit 0 of select 3. No strobe fires. The consumer index stays on the faulting slot, and consumption stops until the queue is disabled.
- R9: Writing 0 to the enable bit clears the producer index, the consumer index and the error flag.
- R10: `q_full` is high when the slot numbers of the producer and consumer are equal and their wrap bits differ. A full queue drains all 16 commands.
- R11: Writes to the consumer index register (select 2) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hr_wr | input | 1 | Host register write strobe |
| hr_sel | input | 2 | Register select: 0 control, 1 producer, 2 consumer, 3 error |
| hr_wdata | input | 32 | Host write data |
| hr_rdata | output | 32 | Combinational read data of the selected register |
| ram_we | input | 1 | Command RAM write enable |
| ram_waddr | input | 4 | Command slot to write |
| ram_wdata | input | 128 | Command; word 0 in bits 63:0, word 1 in bits 127:64 |
| op_stb | output | 8 | One-cycle strobe, one bit per supported opcode |
| sync_stb | output | 1 | One-cycle sync completion strobe |
| cmd_asid | output | 16 | ASID parameter of the last command |
| cmd_vmid | output | 16 | VMID parameter of the last command |
| cmd_range | output | 5 | Range parameter of the last command |
| sync_cs | output | 2 | Completion-signal field of the last command |
| sync_data | output | 32 | Sync payload of the last command |
| q_full | output | 1 | Queue holds 16 pending commands |
| cmd_err | output | 1 | Sticky unknown-opcode error |

## Verification
The assertions assume the host never advances the producer index more than 16 commands past the consumer index. They also assume the host does not rewrite a slot between publishing it and seeing it consumed. The stimulus respects both: each slot is written before the producer write that publishes it, and the queue is filled to 16 commands only from a cleared state. The ordering and error checks further rely on the consumer index moving only by engine increments or by a disable write. The bench never writes the consumer register except in the one check that confirms such writes are ignored.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
   localparam int unsigned OPC_W   = 8;
   localparam int unsigned N_STB   = 8;
   localparam int unsigned WORD_W  = 64;
   localparam logic [OPC_W-1:0] OPC_SYNC = 8'h46;

   localparam logic [1:0] SEL_CTRL = 2'd0;
   localparam logic [1:0] SEL_PROD = 2'd1;
   localparam logic [1:0] SEL_CONS = 2'd2;
   localparam logic [1:0] SEL_ERR  = 2'd3;

   typedef enum logic {PH_FETCH, PH_EXEC} phase_e;

   typedef struct packed {
      logic [N_STB-1:0] stb;
      logic             is_sync;
      logic             known;
      logic [15:0]      asid;
      logic [15:0]      vmid;
      logic [4:0]       range_f;
      logic [1:0]       cs;
      logic [31:0]      sdata;
   } dec_t;

   // opcode that lights strobe bit i
   function automatic logic [OPC_W-1:0] stb_opcode(input int unsigned i);
      case (i)
         0:       return 8'h01;
         1:       return 8'h03;
         2:       return 8'h04;
         3:       return 8'h05;
         4:       return 8'h06;
         5:       return 8'h11;
         6:       return 8'h20;
         default: return 8'h30;
      endcase
   endfunction
endpackage

// File: rtl/cmdq_ram.sv
module cmdq_ram #(
   parameter int unsigned SLOT_W = 4,
   parameter int unsigned CMD_W  = 128
) (
   input  logic              clk,
   input  logic              we,
   input  logic [SLOT_W-1:0] waddr,
   input  logic [CMD_W-1:0]  wdata,
   input  logic              rd_en,
   input  logic [SLOT_W-1:0] raddr,
   output logic [CMD_W-1:0]  rdata
);
   localparam int unsigned DEPTH = 1 << SLOT_W;

   if (SLOT_W < 1 || SLOT_W > 8) begin : g_bad_depth
      $error("cmdq_ram: SLOT_W out of range");
   end

   logic [CMD_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (rd_en) rdata <= mem[raddr];
   end
endmodule

// File: rtl/cmdq_decode.sv
module cmdq_decode
   import cmdq_pkg::*;
(
   input  logic [2*WORD_W-1:0] cmd,
   output dec_t                dec
);
   logic [WORD_W-1:0] w0, w1;
   logic [OPC_W-1:0]  op;
   logic [N_STB-1:0]  hit;

   assign w0 = cmd[WORD_W-1:0];
   assign w1 = cmd[2*WORD_W-1:WORD_W];
   assign op = w0[OPC_W-1:0];

   for (genvar i = 0; i < N_STB; i++) begin : g_op
      assign hit[i] = (op == stb_opcode(i));
   end

   always_comb begin
      dec         = '0;
      dec.stb     = hit;
      dec.is_sync = (op == OPC_SYNC);
      dec.known   = (|hit) || dec.is_sync;
      dec.asid    = w0[63:48];
      dec.vmid    = w0[47:32];
      dec.range_f = w1[4:0];
      dec.cs      = w0[13:12];
      dec.sdata   = w0[63:32];
   end
endmodule

// File: rtl/cmdq_regs.sv
module cmdq_regs
   import cmdq_pkg::*;
#(
   parameter int unsigned SLOT_W = 4,
   parameter int unsigned REG_W  = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hr_wr,
   input  logic [1:0]       hr_sel,
   input  logic [REG_W-1:0] hr_wdata,
   input  logic             adv,
   input  logic             set_err,
   output logic             en,
   output logic             err,
   output logic [SLOT_W:0]  prod,
   output logic [SLOT_W:0]  cons,
   output logic             kill,
   output logic [REG_W-1:0] hr_rdata
);
   localparam int unsigned IDX_W = SLOT_W + 1;

   if (REG_W < IDX_W) begin : g_bad_reg
      $error("cmdq_regs: REG_W narrower than index");
   end

   logic wr_ctrl, wr_prod;
   assign wr_ctrl = hr_wr && (hr_sel == SEL_CTRL);
   assign wr_prod = hr_wr && (hr_sel == SEL_PROD);
   assign kill    = wr_ctrl && !hr_wdata[0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en   <= 1'b0;
         err  <= 1'b0;
         prod <= '0;
         cons <= '0;
      end else begin
         if (wr_ctrl) en <= hr_wdata[0];
         if (kill) begin
            prod <= '0;
            cons <= '0;
            err  <= 1'b0;
         end else begin
            if (wr_prod) prod <= hr_wdata[IDX_W-1:0];
            if (adv)     cons <= cons + 1'b1;
            if (set_err) err  <= 1'b1;
         end
      end
   end

   always_comb begin
      hr_rdata = '0;
      case (hr_sel)
         SEL_CTRL: hr_rdata[0]       = en;
         SEL_PROD: hr_rdata[IDX_W-1:0] = prod;
         SEL_CONS: hr_rdata[IDX_W-1:0] = cons;
         default:  hr_rdata[0]       = err;
      endcase
   end
endmodule

// File: rtl/cmdq_engine.sv
module cmdq_engine
   import cmdq_pkg::*;
#(
   parameter int unsigned SLOT_W = 4,
   parameter int unsigned REG_W  = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 hr_wr,
   input  logic [1:0]           hr_sel,
   input  logic [REG_W-1:0]     hr_wdata,
   output logic [REG_W-1:0]     hr_rdata,
   input  logic                 ram_we,
   input  logic [SLOT_W-1:0]    ram_waddr,
   input  logic [2*WORD_W-1:0]  ram_wdata,
   output logic [N_STB-1:0]     op_stb,
   output logic                 sync_stb,
   output logic [15:0]          cmd_asid,
   output logic [15:0]          cmd_vmid,
   output logic [4:0]           cmd_range,
   output logic [1:0]           sync_cs,
   output logic [31:0]          sync_data,
   output logic                 q_full,
   output logic                 cmd_err
);
   localparam int unsigned IDX_W = SLOT_W + 1;
   localparam int unsigned CMD_W = 2 * WORD_W;

   logic             q_en, kill, adv, set_err, fetch_go, exec;
   logic [IDX_W-1:0] q_prod, q_cons;
   logic [CMD_W-1:0] cmd_q;
   phase_e           ph;
   dec_t             dec;

   cmdq_regs #(.SLOT_W(SLOT_W), .REG_W(REG_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .hr_wr(hr_wr), .hr_sel(hr_sel),
      .hr_wdata(hr_wdata), .adv(adv), .set_err(set_err), .en(q_en),
      .err(cmd_err), .prod(q_prod), .cons(q_cons), .kill(kill),
      .hr_rdata(hr_rdata)
   );

   cmdq_ram #(.SLOT_W(SLOT_W), .CMD_W(CMD_W)) u_ram (
      .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
      .rd_en(fetch_go), .raddr(q_cons[SLOT_W-1:0]), .rdata(cmd_q)
   );

   cmdq_decode u_dec (.cmd(cmd_q), .dec(dec));

   assign fetch_go = (ph == PH_FETCH) && q_en && (q_prod != q_cons)
                     && !cmd_err && !kill;
   assign exec     = (ph == PH_EXEC) && !kill;
   assign adv      = exec && dec.known;
   assign set_err  = exec && !dec.known;
   assign q_full   = (q_prod[SLOT_W-1:0] == q_cons[SLOT_W-1:0])
                     && (q_prod[SLOT_W] != q_cons[SLOT_W]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph        <= PH_FETCH;
         op_stb    <= '0;
         sync_stb  <= 1'b0;
         cmd_asid  <= '0;
         cmd_vmid  <= '0;
         cmd_range <= '0;
         sync_cs   <= '0;
         sync_data <= '0;
      end else begin
         op_stb   <= exec ? dec.stb : '0;
         sync_stb <= exec && dec.is_sync;
         if (adv) begin
            cmd_asid  <= dec.asid;
            cmd_vmid  <= dec.vmid;
            cmd_range <= dec.range_f;
            sync_cs   <= dec.cs;
            sync_data <= dec.sdata;
         end
         if (kill)          ph <= PH_FETCH;
         else if (fetch_go) ph <= PH_EXEC;
         else               ph <= PH_FETCH;
      end
   end
endmodule

// File: rtl/cmdq_engine_chk.sv
module cmdq_engine_chk #(
   parameter int unsigned SLOT_W = 4,
   parameter int unsigned N_STB  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              kill,
   input logic              q_en,
   input logic [SLOT_W:0]   q_cons,
   input logic [N_STB-1:0]  op_stb,
   input logic              sync_stb,
   input logic              cmd_err
);
   logic any_stb;
   assign any_stb = (|op_stb) || sync_stb;

   // R4: at most one strobe, never together with sync (R7)
   a_r4_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({op_stb, sync_stb}));

   // R3: consumer index only steps by one or is cleared
   a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
      (q_cons != $past(q_cons)) |-> (q_cons == $past(q_cons) + 1'b1 || q_cons == '0));

   // R3: a strobe coincides with a consumer advance
   a_r3_adv: assert property (@(posedge clk) disable iff (!rst_n)
      any_stb |-> (q_cons == $past(q_cons) + 1'b1));

   // R3: strobes are single cycle, commands two cycles apart
   a_r3_gap: assert property (@(posedge clk) disable iff (!rst_n)
      any_stb |=> !any_stb);

   // R2: nothing fires while disabled
   a_r2_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !q_en |-> !any_stb);

   // R8: error is sticky and freezes the consumer
   a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_err && !kill) |=> (cmd_err && $stable(q_cons)));

   // R8: no strobe while in error
   a_r8_silent: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_err |-> !any_stb);
endmodule

bind cmdq_engine cmdq_engine_chk #(.SLOT_W(SLOT_W), .N_STB(cmdq_pkg::N_STB)) u_chk (
   .clk(clk), .rst_n(rst_n), .kill(kill), .q_en(q_en), .q_cons(q_cons),
   .op_stb(op_stb), .sync_stb(sync_stb), .cmd_err(cmd_err)
);

// File: tb/cmdq_engine_tb.sv
module cmdq_engine_tb;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         hr_wr = 1'b0;
   logic [1:0]   hr_sel = 2'd0;
   logic [31:0]  hr_wdata = '0;
   logic [31:0]  hr_rdata;
   logic         ram_we = 1'b0;
   logic [3:0]   ram_waddr = '0;
   logic [127:0] ram_wdata = '0;
   logic [7:0]   op_stb;
   logic         sync_stb, q_full, cmd_err;
   logic [15:0]  cmd_asid, cmd_vmid;
   logic [4:0]   cmd_range;
   logic [1:0]   sync_cs;
   logic [31:0]  sync_data;

   int n_chk = 0, n_fail = 0, n_pulse = 0;

   always #2 clk = ~clk;

   cmdq_engine u_dut (
      .clk(clk), .rst_n(rst_n), .hr_wr(hr_wr), .hr_sel(hr_sel),
      .hr_wdata(hr_wdata), .hr_rdata(hr_rdata), .ram_we(ram_we),
      .ram_waddr(ram_waddr), .ram_wdata(ram_wdata), .op_stb(op_stb),
      .sync_stb(sync_stb), .cmd_asid(cmd_asid), .cmd_vmid(cmd_vmid),
      .cmd_range(cmd_range), .sync_cs(sync_cs), .sync_data(sync_data),
      .q_full(q_full), .cmd_err(cmd_err)
   );

   always @(negedge clk) if ((|op_stb) || sync_stb) n_pulse++;

   localparam int NV = 10;
   localparam logic [63:0] V_W0 [NV] = '{
      64'h0000_0000_0000_0001, 64'h0000_0000_0000_0003,
      64'h0000_0000_0000_0004, 64'h0000_0000_0000_0005,
      64'h0000_0000_0000_0006, 64'hBEEF_0123_0000_0011,
      64'h0000_0000_0000_0020, 64'h0000_0000_0000_0030,
      64'hCAFE_F00D_0FC0_2046, 64'h0000_0000_0000_0004};
   localparam logic [63:0] V_W1 [NV] = '{
      64'h0, 64'h0, 64'h1f, 64'h0, 64'h0, 64'h0, 64'h0, 64'h0, 64'h0, 64'h5};
   localparam logic [8:0] V_STB [NV] = '{   // {sync, op_stb}
      9'h001, 9'h002, 9'h004, 9'h008, 9'h010,
      9'h020, 9'h040, 9'h080, 9'h100, 9'h004};

   task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic hwrite(input logic [1:0] sel, input logic [31:0] d);
      hr_wr = 1'b1; hr_sel = sel; hr_wdata = d;
      @(negedge clk);
      hr_wr = 1'b0;
   endtask

   task automatic hread(input logic [1:0] sel, output logic [31:0] d);
      hr_sel = sel;
      #1 d = hr_rdata;
   endtask

   task automatic put(input logic [3:0] slot, input logic [63:0] w0, input logic [63:0] w1);
      ram_we = 1'b1; ram_waddr = slot; ram_wdata = {w1, w0};
      @(negedge clk);
      ram_we = 1'b0;
   endtask

   task automatic waitn(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic finish_run;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] rd;
      int base;
      waitn(3);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      for (int s = 0; s < 4; s++) begin
         hread(2'(s), rd);
         chk(rd, 0, "R1 register reads zero");
      end
      chk({op_stb, sync_stb, cmd_err, q_full}, 0, "R1 outputs idle");

      // R2 disabled queue does not consume
      put(4'd0, 64'h1, 64'h0);
      hwrite(2'd1, 32'd1);
      waitn(6);
      chk(n_pulse, 0, "R2 no strobe while disabled");
      hread(2'd2, rd);
      chk(rd, 0, "R2 consumer unchanged while disabled");
      hwrite(2'd0, 32'd0);
      hwrite(2'd0, 32'd1);

      // vector table R3..R7
      for (int i = 0; i < NV; i++) begin
         put(4'(i), V_W0[i], V_W1[i]);
         hwrite(2'd1, 32'(i + 1));
         waitn(2);
         chk({sync_stb, op_stb}, V_STB[i], "R4 strobe for opcode");
         hread(2'd2, rd);
         chk(rd, i + 1, "R3 consumer advance");
         if (V_W0[i][7:0] == 8'h11) begin
            chk(cmd_asid, 16'hBEEF, "R5 asid");
            chk(cmd_vmid, 16'h0123, "R5 vmid");
         end
         if (V_W0[i][7:0] == 8'h04) chk(cmd_range, V_W1[i][4:0], "R6 range");
         if (V_W0[i][7:0] == 8'h46) begin
            chk(sync_data, 32'hCAFEF00D, "R7 sync data");
            chk(sync_cs, 2'd2, "R7 sync cs");
         end
         @(negedge clk);
         chk({sync_stb, op_stb}, 0, "R3 strobe lasts one cycle");
      end

      // R10 full queue and wrap
      hwrite(2'd0, 32'd0);
      for (int i = 0; i < 16; i++) put(4'(i), 64'h1, 64'h0);
      hwrite(2'd1, 32'h10);
      chk(q_full, 1, "R10 full flag");
      base = n_pulse;
      hwrite(2'd0, 32'd1);
      waitn(40);
      chk(n_pulse - base, 16, "R10 sixteen commands drained");
      hread(2'd2, rd);
      chk(rd, 32'h10, "R3 wrap bit toggled");
      chk(q_full, 0, "R10 full clears when drained");

      // R11 consumer register read-only
      hwrite(2'd2, 32'd3);
      hread(2'd2, rd);
      chk(rd, 32'h10, "R11 consumer write ignored");

      // R8 unknown opcode
      put(4'd0, 64'h77, 64'h0);
      put(4'd1, 64'h1, 64'h0);
      base = n_pulse;
      hwrite(2'd1, 32'h12);
      waitn(2);
      chk(cmd_err, 1, "R8 error raised");
      hread(2'd2, rd);
      chk(rd, 32'h10, "R8 consumer holds on bad slot");
      waitn(8);
      chk(n_pulse - base, 0, "R8 consumption halted");
      hread(2'd3, rd);
      chk(rd, 1, "R8 error register");

      // R9 disable clears
      hwrite(2'd0, 32'd0);
      hread(2'd1, rd);
      chk(rd, 0, "R9 producer cleared");
      hread(2'd2, rd);
      chk(rd, 0, "R9 consumer cleared");
      chk(cmd_err, 0, "R9 error cleared");

      // R7 sync after earlier commands
      hwrite(2'd0, 32'd1);
      put(4'd0, 64'h3, 64'h0);
      put(4'd1, 64'h5, 64'h0);
      put(4'd2, 64'h1234_5678_0000_1046, 64'h0);
      hwrite(2'd1, 32'd3);
      waitn(2);
      chk({sync_stb, op_stb}, 9'h002, "R7 first earlier command");
      waitn(2);
      chk({sync_stb, op_stb}, 9'h008, "R7 second earlier command");
      waitn(2);
      chk(sync_stb, 1, "R7 sync completes last");
      hread(2'd2, rd);
      chk(rd, 3, "R7 all earlier consumed at sync");
      chk(sync_data, 32'h12345678, "R7 sync data");
      chk(sync_cs, 2'd1, "R7 sync cs");

      finish_run();
   end
endmodule